// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends bytes to a smart card over one shared, open-drain I/O line. Each byte goes out as a character of ten bit times: a low start bit, eight data bits with the least significant bit first, and an even parity bit. After the parity bit the line is released to its high level. The card signals a bad character by pulling the line low near the end of the guard period. The block samples the line at that point. If it finds an error it sets a sticky error flag and sends the same byte again without any action from the host.

The host gives a transmit enable, a mode bit that selects early or late completion, two interrupt enables, and a write strobe with a data byte. It reads back a data-empty flag, a transmit-end flag and the error flag. The block also drives a level interrupt for each of transmit end and error. Timing comes from a tick input that pulses twice per elementary time unit (etu). The block has no baud generator of its own.

Top module: `sc_char_tx`

## Requirements
- R1: Each attempt drives one half-etu tick pair per bit, and `io_oe_o`=1 pulls the line low. The bit order is a low start bit, then data bits 0 to 7, then an even parity bit over the eight data bits. A data bit of value b is driven as `io_oe_o`=!b.
- R2: From 10 etu (tick 20) after the start edge until the next start edge, `io_oe_o` is 0.
- R3: A write (`wr_i`=1) is accepted only when `te_i`=1, `ers_o`=0 and `tend_o`=1. An accepted write clears `tdre_o` and `tend_o` on the next clock. The start edge follows on the next tick.
- R4: `tdre_o` returns to 1 on the clock that drives the start bit of the first attempt.
- R5: The line is sampled at 11 etu (tick 22) after the start edge. A low sample sets `ers_o`.
- R6: After an error, the same byte is sent again, and its start edge falls at 13 etu (tick 26) after the failed start edge. This repeats until an attempt is clean.
- R7: On a clean attempt, `tend_o` rises at tick 25 (12.5 etu) when `gm_i`=0, or at tick 22 (11 etu) when `gm_i`=1. It is 0 one tick before that point.
- R8: `txi_o` is `tend_o` AND `tie_i`. `eri_o` is `ers_o` AND `rie_i`.
- R9: `ers_o` stays set until a one-clock pulse on `ers_clr_i`. While it is set, host writes are ignored: the flags do not change and no start bit is driven.
- R10: When `te_i` is 0, the line is released on the next clock, `tdre_o` and `tend_o` read 1, and writes are ignored.
- R11: After reset, `io_oe_o`=0, `tdre_o`=1, `tend_o`=1 and `ers_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half-etu tick, one clock wide |
| te_i | input | 1 | Transmit enable |
| tie_i | input | 1 | Transmit-end interrupt enable |
| rie_i | input | 1 | Error interrupt enable |
| gm_i | input | 1 | Early completion mode (1 = tick 22, 0 = tick 25) |
| wr_i | input | 1 | Data register write strobe |
| wdata_i | input | 8 | Byte to send |
| ers_clr_i | input | 1 | Clear pulse for the error flag |
| io_i | input | 1 | Line level, asynchronous |
| io_oe_o | output | 1 | 1 pulls the line low |
| tdre_o | output | 1 | Data register empty |
| tend_o | output | 1 | Transmission ended |
| ers_o | output | 1 | Sticky error status |
| txi_o | output | 1 | Transmit-end interrupt |
| eri_o | output | 1 | Error interrupt |

## Verification
The half-etu counter sets when every bit edge, sample point, retry and completion happens, so a counter that is off by one shows at the ports within a single character. The frame slips by one tick, or `tend_o` or the retry start edge moves away from tick 22, 25 or 26. A retry flag that stays set after a clean attempt shows as `tend_o` never rising and a new start edge at tick 26. A lost error flag shows as soon as the next host write is accepted when it should have been ignored. The bench measures each of these events in ticks from the observed start edge.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_SEND
  } tx_state_e;
endpackage

// File: rtl/sc_line_sync.sv
module sc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b1;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sc_frame_gen.sv
module sc_frame_gen #(
  parameter int DATA_W = 8,
  parameter int HW     = 5
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [HW-1:0]     half_idx_i,
  output logic              drive_o
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int IW = HW - 1;

  logic [FRAME_BITS-1:0] frame;
  logic [IW-1:0]         bit_idx;

  assign frame   = {^data_i, data_i, 1'b0};
  assign bit_idx = half_idx_i[HW-1:1];

  // past the parity bit the line is released
  always_comb begin
    drive_o = 1'b0;
    for (int i = 0; i < FRAME_BITS; i++) begin
      if (bit_idx == IW'(i)) drive_o = ~frame[i];
    end
  end
endmodule

// File: rtl/sc_tx_ctrl.sv
module sc_tx_ctrl
  import sc_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              te_i,
  input  logic              gm_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ers_clr_i,
  input  logic              line_i,
  output logic              line_oe_o,
  output logic              tdre_o,
  output logic              tend_o,
  output logic              ers_o
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int GUARD_H    = 2 * FRAME_BITS;
  localparam int SAMPLE_H   = GUARD_H + 2;
  localparam int END_GM1_H  = SAMPLE_H;
  localparam int END_GM0_H  = SAMPLE_H + 3;
  localparam int RETRY_H    = SAMPLE_H + 4;
  localparam int HW         = $clog2(RETRY_H + 1);
  localparam logic [HW-1:0] GUARD_V   = HW'(GUARD_H);
  localparam logic [HW-1:0] SAMPLE_V  = HW'(SAMPLE_H);
  localparam logic [HW-1:0] END_GM1_V = HW'(END_GM1_H);
  localparam logic [HW-1:0] END_GM0_V = HW'(END_GM0_H);
  localparam logic [HW-1:0] RETRY_V   = HW'(RETRY_H);

  tx_state_e         state_q;
  logic [HW-1:0]     h_q, h_inc, h_sel;
  logic [DATA_W-1:0] data_q;
  logic              oe_q, tdre_q, tend_q, ers_q, retry_q;
  logic              restart, wr_ok, drive, end_hit;

  always_comb begin
    h_inc   = h_q + 1'b1;
    restart = (state_q == ST_SEND) && retry_q && (h_inc == RETRY_V);
    h_sel   = ((state_q == ST_ARM) || restart) ? '0 : h_inc;
    wr_ok   = wr_i && te_i && !ers_q && tend_q;
    end_hit = !retry_q && (gm_i ? (h_inc == END_GM1_V) : (h_inc == END_GM0_V));
  end

  sc_frame_gen #(.DATA_W(DATA_W), .HW(HW)) u_frame (
    .data_i     (data_q),
    .half_idx_i (h_sel),
    .drive_o    (drive)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      h_q     <= '0;
      data_q  <= '0;
      oe_q    <= 1'b0;
      tdre_q  <= 1'b1;
      tend_q  <= 1'b1;
      ers_q   <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      if (ers_clr_i) ers_q <= 1'b0;
      if (!te_i) begin
        state_q <= ST_IDLE;
        h_q     <= '0;
        oe_q    <= 1'b0;
        tdre_q  <= 1'b1;
        tend_q  <= 1'b1;
        retry_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (wr_ok) begin
              data_q  <= wdata_i;
              tdre_q  <= 1'b0;
              tend_q  <= 1'b0;
              state_q <= ST_ARM;
            end
          end
          ST_ARM: begin
            if (tick_i) begin
              state_q <= ST_SEND;
              h_q     <= h_sel;
              oe_q    <= drive;
              tdre_q  <= 1'b1;
              retry_q <= 1'b0;
            end
          end
          ST_SEND: begin
            if (tick_i) begin
              h_q  <= h_sel;
              oe_q <= drive;
              if (h_inc == SAMPLE_V && !line_i) begin
                retry_q <= 1'b1;
                ers_q   <= 1'b1;
              end else if (end_hit) begin
                tend_q  <= 1'b1;
                state_q <= ST_IDLE;
              end
              if (restart) retry_q <= 1'b0;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign line_oe_o = oe_q;
  assign tdre_o    = tdre_q;
  assign tend_o    = tend_q;
  assign ers_o     = ers_q;

  // R3
  wr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (!tend_q && !tdre_q));

  // R9
  ers_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ers_q && !ers_clr_i) |=> ers_q);

  // R10
  te_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !te_i |=> !line_oe_o);

  // R2
  guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND && h_q >= GUARD_V) |-> !line_oe_o);

  // R7
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> !tend_q);
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              te_i,
  input  logic              tie_i,
  input  logic              rie_i,
  input  logic              gm_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ers_clr_i,
  input  logic              io_i,
  output logic              io_oe_o,
  output logic              tdre_o,
  output logic              tend_o,
  output logic              ers_o,
  output logic              txi_o,
  output logic              eri_o
);
  logic line_s;

  sc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (io_i),
    .q_o    (line_s)
  );

  sc_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .te_i      (te_i),
    .gm_i      (gm_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .ers_clr_i (ers_clr_i),
    .line_i    (line_s),
    .line_oe_o (io_oe_o),
    .tdre_o    (tdre_o),
    .tend_o    (tend_o),
    .ers_o     (ers_o)
  );

  assign txi_o = tie_i & tend_o;
  assign eri_o = rie_i & ers_o;

  // R8
  irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txi_o |-> tend_o) and (eri_o |-> ers_o));
endmodule

// File: tb/sc_char_tx_test.sv
module sc_char_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       te_i = 1'b0, tie_i = 1'b0, rie_i = 1'b0, gm_i = 1'b0;
  logic       wr_i = 1'b0, ers_clr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       io_i;
  logic       io_oe_o, tdre_o, tend_o, ers_o, txi_o, eri_o;
  logic       card_low = 1'b0;
  int         total = 0, bad = 0, tcnt = 0;

  assign io_i = !(io_oe_o || card_low);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(negedge clk_i) begin
    tcnt   <= (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
    tick_i <= (tcnt == TICK_DIV-1);
  end

  sc_char_tx uut (
    .clk_i, .rst_ni, .tick_i, .te_i, .tie_i, .rie_i, .gm_i,
    .wr_i, .wdata_i, .ers_clr_i, .io_i,
    .io_oe_o, .tdre_o, .tend_o, .ers_o, .txi_o, .eri_o
  );

  // data[10:3], gm[2], error count[1:0]
  localparam logic [10:0] VEC [6] = '{
    {8'hA5, 1'b0, 2'd0}, {8'h3C, 1'b1, 2'd0}, {8'hFF, 1'b0, 2'd1},
    {8'h00, 1'b1, 2'd1}, {8'h81, 1'b0, 2'd2}, {8'h5A, 1'b1, 2'd2}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_tick();
    logic seen = 1'b0;
    while (!seen) begin
      @(posedge clk_i);
      seen = tick_i;
    end
    #1;
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk_i); wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic clear_ers();
    @(negedge clk_i); ers_clr_i = 1'b1;
    @(negedge clk_i); ers_clr_i = 1'b0;
    chk("R9", "ers after clear", ers_o, 0);
    chk("R8", "eri after clear", eri_o, 0);
  endtask

  task automatic no_start(input string req, input int n);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      wait_tick();
      if (io_oe_o) hits++;
    end
    chk(req, "start edges while blocked", hits, 0);
  endtask

  task automatic send_char(input logic [7:0] d, input logic g, input int nerr);
    int         errs_left = nerr;
    logic [9:0] exp_f = {^d, d, 1'b0};
    logic [9:0] got;
    logic       seen = 1'b0;
    bit         done = 1'b0;
    int         guard_bad;
    int         t_end = g ? 22 : 25;
    gm_i = g;
    host_write(d);
    chk("R3", "tend after write", tend_o, 0);
    chk("R3", "tdre after write", tdre_o, 0);
    for (int i = 0; i < 4 && !seen; i++) begin
      wait_tick();
      seen = io_oe_o;
    end
    chk("R3", "start edge seen", seen, 1);
    chk("R4", "tdre at start", tdre_o, 1);
    while (!done) begin
      got = '0;
      guard_bad = 0;
      for (int hh = 1; hh <= 27; hh++) begin
        wait_tick();
        if (hh % 2 == 1 && hh < 20) got[hh/2] = !io_oe_o;
        if (hh == 20) chk("R1", "frame bits", got, exp_f);
        if (hh >= 20 && io_oe_o && hh < 26) guard_bad++;
        if (hh == 21) card_low = (errs_left > 0);
        if (hh == 23) card_low = 1'b0;
        if (errs_left > 0) begin
          if (hh == 22) begin
            chk("R5", "ers after error sample", ers_o, 1);
            chk("R8", "eri with rie", eri_o, 1);
          end
          if (hh == 25) chk("R6", "line before retry", io_oe_o, 0);
          if (hh == 26) begin
            chk("R6", "retry start edge at tick 26", io_oe_o, 1);
            errs_left--;
            break;
          end
        end else begin
          if (hh == t_end - 1) chk("R7", "tend before end tick", tend_o, 0);
          if (hh == t_end) begin
            chk("R7", "tend at end tick", tend_o, 1);
            chk("R8", "txi with tie", txi_o, 1);
            done = 1'b1;
            break;
          end
        end
      end
      chk("R2", "guard drive count", guard_bad, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11", "oe after reset", io_oe_o, 0);
    chk("R11", "tdre after reset", tdre_o, 1);
    chk("R11", "tend after reset", tend_o, 1);
    chk("R11", "ers after reset", ers_o, 0);
    chk("R8", "txi with tie low", txi_o, 0);
    chk("R8", "eri with rie low", eri_o, 0);

    // writes ignored while disabled
    host_write(8'h12);
    chk("R10", "tend with te low", tend_o, 1);
    no_start("R10", 30);

    te_i = 1'b1; tie_i = 1'b1; rie_i = 1'b1;
    for (int v = 0; v < 6; v++) begin
      send_char(VEC[v][10:3], VEC[v][2], int'(VEC[v][1:0]));
      if (VEC[v][1:0] != 2'd0) clear_ers();
    end

    // error flag blocks writes
    send_char(8'h66, 1'b0, 1);
    host_write(8'h11);
    chk("R9", "tend while ers set", tend_o, 1);
    chk("R9", "tdre while ers set", tdre_o, 1);
    no_start("R9", 30);
    clear_ers();
    send_char(8'h11, 1'b1, 0);

    // disable mid character
    gm_i = 1'b0;
    host_write(8'hC3);
    repeat (8) wait_tick();
    @(negedge clk_i); te_i = 1'b0;
    @(negedge clk_i);
    chk("R10", "line after te low", io_oe_o, 0);
    chk("R10", "tend after te low", tend_o, 1);
    chk("R10", "tdre after te low", tdre_o, 1);
    no_start("R10", 30);
    te_i = 1'b1;
    send_char(8'h96, 1'b0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule